// File: doc/BRIEF.md
# Branch-Indexed Way-Pointer Mode Controller

This block steers an n-way set-associative instruction cache so that, on code it has already seen, the cache can light up a single way and skip the tag lookup entirely. It keeps a small table of way pointers, one row per branch-target-buffer entry, with a separate pointer set for the taken and the not-taken path of that branch. When a branch hits in the BTB, the set chosen by the prediction is looked up. A valid set is replayed line by line as the fetch stream crosses cache-line boundaries. An invalid set starts a recording pass, and the hit ways the cache reports are collected until the next BTB hit, which stores them.

Anything that could make a stored pointer stale drops the controller back to plain full-lookup operation. A cache miss or a BTB replacement also discards every stored set. A return-stack target or a branch mispredict falls back to full lookup but keeps the table. Running past the last pointer of a set, during replay or during recording, also falls back to full lookup.

Top module: `wp_mode_ctrl`

## Requirements
- R1: After reset `mode` is 0 (normal), `skip_tag` is 0, `omit_way` is 0, and every table set is invalid, so the first BTB hit on any entry leads to trace mode.
- R2: The `mode` encoding is 0 = normal, 1 = omit, 2 = trace. `skip_tag` is 1 exactly in omit mode, and `omit_way` is 0 whenever the mode is not omit. Outside the events below, normal mode stays normal, including across line strobes.
- R3: A BTB hit whose chosen set is invalid puts the controller in trace mode on the next cycle. The controller remembers the hit's entry index and prediction as the target of the next table write.
- R4: A BTB hit whose chosen set is valid puts the controller in omit mode on the next cycle, with `omit_way` equal to pointer 0 of that set.
- R5: `pred_taken` = 1 selects the taken set and 0 selects the not-taken set of the hit entry. The two sets are recorded and validated independently.
- R6: In omit mode each `line_cross` strobe advances `omit_way` to the next stored pointer, so after k strobes it shows pointer k.
- R7: In trace mode, the k-th `line_cross` strobe stores `cache_hit_way` as pointer k-1. At the next BTB hit, `cache_hit_way` is stored as the final pointer, the set is written to the remembered entry and half, and that set becomes valid.
- R8: A BTB hit sees the table as it was before any write made in the same cycle. A hit on the set being written in that cycle therefore still leads to trace mode, and the following hit on it leads to omit mode.
- R9: In omit mode, a strobe while pointer M-1 (M = `PTRS`) is shown is an overflow and gives normal mode on the next cycle.
- R10: In trace mode, a strobe after M-1 pointers have been stored is an overflow. It gives normal mode, and the recorded set is never written, so that set stays invalid.
- R11: `cache_miss` or `btb_repl` forces normal mode on the next cycle and invalidates every set in the table.
- R12: `ras_target` or `br_mispredict` forces normal mode on the next cycle and leaves the table valid bits unchanged.
- R13: Events in the same cycle are resolved in a fixed order, highest first: miss or replacement, then return-stack target or mispredict, then BTB hit, then line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btb_hit | input | 1 | The fetched branch hit in the BTB this cycle |
| btb_idx | input | 4 | BTB entry index of the hit |
| btb_repl | input | 1 | A BTB entry was replaced this cycle |
| pred_taken | input | 1 | Predicted direction of the hitting branch (1 = taken) |
| ras_target | input | 1 | The fetch target came from the return-address stack |
| br_mispredict | input | 1 | A branch mispredict was detected |
| line_cross | input | 1 | Fetch crossed into the next cache line |
| cache_hit_way | input | 2 | Way that hit for the line being left, or for the current line on a BTB hit |
| cache_miss | input | 1 | The instruction cache missed |
| mode | output | 2 | 0 normal, 1 omit, 2 trace |
| omit_way | output | 2 | Way to enable alone when tags are skipped |
| skip_tag | output | 1 | Suppress the tag lookup and enable only `omit_way` |

## Verification
Every result is registered. An event presented in one cycle shows up on `mode`, `omit_way` and `skip_tag` right after the next rising edge, and a table write becomes visible to the BTB hit that follows it by one or more cycles. The bench changes inputs on the falling edge, holds them for exactly one cycle, clears them on the next falling edge and samples the outputs at that same instant. Each check therefore looks at the cycle directly after its stimulus. Effects on table contents, such as invalidation, validity after recording, or a write that never happened, are observed by issuing a later BTB hit and checking whether omit or trace mode follows.

// File: rtl/wp_mode_pkg.sv
package wp_mode_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_OMIT   = 2'd1,
    MODE_TRACE  = 2'd2
  } wp_mode_e;
endpackage

// File: rtl/wp_ptr_table.sv
// Way-pointer table: one row per (entry, half); half 1 = taken path.
module wp_ptr_table #(
  parameter int ENTRIES = 16,
  parameter int PTRS    = 4,
  parameter int WAY_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ROWS   = 2 * ENTRIES,
  localparam int SET_W  = PTRS * WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_half,
  input  logic [SET_W-1:0] wr_set,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_half,
  output logic             rd_valid,
  output logic [SET_W-1:0] rd_set
);
  logic [SET_W-1:0] set_q [ROWS];
  logic [ROWS-1:0]  vld_q, vld_d;
  logic [SET_W-1:0] set_tk, set_nt;
  logic             vld_tk, vld_nt;

  // both halves read side by side, prediction picks one
  assign set_tk = set_q[{rd_idx, 1'b1}];
  assign set_nt = set_q[{rd_idx, 1'b0}];
  assign vld_tk = vld_q[{rd_idx, 1'b1}];
  assign vld_nt = vld_q[{rd_idx, 1'b0}];
  assign rd_set   = rd_half ? set_tk : set_nt;
  assign rd_valid = rd_half ? vld_tk : vld_nt;

  always_comb begin
    vld_d = vld_q;
    if (clr_all) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[{wr_idx, wr_half}] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // pointer payload carries no reset; it is only read behind a valid bit
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (wr_en && !clr_all && ({wr_idx, wr_half} == r[IDX_W:0])) set_q[r] <= wr_set;
    end
  end
endmodule

// File: rtl/wp_replay.sv
// Holds the set being replayed and the line position within it.
module wp_replay #(
  parameter int PTRS   = 4,
  parameter int WAY_W  = 2,
  localparam int POS_W = (PTRS > 1) ? $clog2(PTRS) : 1,
  localparam int SET_W = PTRS * WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] load_set,
  input  logic             adv,
  output logic [WAY_W-1:0] cur_way,
  output logic             at_last
);
  logic [SET_W-1:0] set_q;
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (load)     pos_d = '0;
    else if (adv) pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  always_ff @(posedge clk) begin
    if (load) set_q <= load_set;
  end

  assign cur_way = set_q[pos_q*WAY_W +: WAY_W];
  assign at_last = (pos_q == POS_W'(PTRS - 1));
endmodule

// File: rtl/wp_record.sv
// Collects hit ways line by line; the tail slot is filled from the live input.
module wp_record #(
  parameter int PTRS   = 4,
  parameter int WAY_W  = 2,
  localparam int POS_W = (PTRS > 1) ? $clog2(PTRS) : 1,
  localparam int SET_W = PTRS * WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             push,
  input  logic [WAY_W-1:0] way_in,
  output logic [SET_W-1:0] out_set,
  output logic             at_last
);
  logic [WAY_W-1:0] slot_q [PTRS];
  logic [POS_W-1:0] fill_q, fill_d;

  always_comb begin
    fill_d = fill_q;
    if (start)     fill_d = '0;
    else if (push) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  always_ff @(posedge clk) begin
    if (push && !start) slot_q[fill_q] <= way_in;
  end

  // slot at the fill position takes the way of the line holding the branch
  for (genvar k = 0; k < PTRS; k++) begin : g_slot
    assign out_set[k*WAY_W +: WAY_W] = (fill_q == POS_W'(k)) ? way_in : slot_q[k];
  end

  assign at_last = (fill_q == POS_W'(PTRS - 1));
endmodule

// File: rtl/wp_mode_ctrl.sv
module wp_mode_ctrl #(
  parameter int WAYS    = 4,
  parameter int PTRS    = 4,
  parameter int ENTRIES = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SET_W  = PTRS * WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btb_hit,
  input  logic [IDX_W-1:0] btb_idx,
  input  logic             btb_repl,
  input  logic             pred_taken,
  input  logic             ras_target,
  input  logic             br_mispredict,
  input  logic             line_cross,
  input  logic [WAY_W-1:0] cache_hit_way,
  input  logic             cache_miss,
  output logic [1:0]       mode,
  output logic [WAY_W-1:0] omit_way,
  output logic             skip_tag
);
  import wp_mode_pkg::*;

  // reset: asserts at once, leaves on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wp_mode_e         mode_q, mode_d;
  logic [IDX_W-1:0] prev_idx_q;
  logic             prev_half_q;
  logic             prev_cap;
  logic             tbl_clr, tbl_wr, tbl_vld;
  logic [SET_W-1:0] tbl_set, rec_set;
  logic             rp_load, rp_adv, rp_last;
  logic             rc_start, rc_push, rc_last;
  logic [WAY_W-1:0] rp_way;

  // next-state: miss/repl > ras/mispredict > btb hit > line strobe
  always_comb begin
    mode_d   = mode_q;
    tbl_clr  = 1'b0;
    tbl_wr   = 1'b0;
    rp_load  = 1'b0;
    rp_adv   = 1'b0;
    rc_start = 1'b0;
    rc_push  = 1'b0;
    prev_cap = 1'b0;
    if (cache_miss || btb_repl) begin
      tbl_clr = 1'b1;
      mode_d  = MODE_NORMAL;
    end else if (ras_target || br_mispredict) begin
      mode_d = MODE_NORMAL;
    end else if (btb_hit) begin
      tbl_wr = (mode_q == MODE_TRACE);
      if (tbl_vld) begin
        mode_d  = MODE_OMIT;
        rp_load = 1'b1;
      end else begin
        mode_d   = MODE_TRACE;
        rc_start = 1'b1;
        prev_cap = 1'b1;
      end
    end else if (line_cross) begin
      if (mode_q == MODE_OMIT) begin
        if (rp_last) mode_d = MODE_NORMAL;
        else         rp_adv = 1'b1;
      end else if (mode_q == MODE_TRACE) begin
        if (rc_last) mode_d = MODE_NORMAL;
        else         rc_push = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= MODE_NORMAL;
    else            mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prev_idx_q  <= '0;
      prev_half_q <= 1'b0;
    end else if (prev_cap) begin
      prev_idx_q  <= btb_idx;
      prev_half_q <= pred_taken;
    end
  end

  wp_ptr_table #(.ENTRIES(ENTRIES), .PTRS(PTRS), .WAY_W(WAY_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_all  (tbl_clr),
    .wr_en    (tbl_wr),
    .wr_idx   (prev_idx_q),
    .wr_half  (prev_half_q),
    .wr_set   (rec_set),
    .rd_idx   (btb_idx),
    .rd_half  (pred_taken),
    .rd_valid (tbl_vld),
    .rd_set   (tbl_set)
  );

  wp_replay #(.PTRS(PTRS), .WAY_W(WAY_W)) u_replay (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (rp_load),
    .load_set (tbl_set),
    .adv      (rp_adv),
    .cur_way  (rp_way),
    .at_last  (rp_last)
  );

  wp_record #(.PTRS(PTRS), .WAY_W(WAY_W)) u_record (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (rc_start),
    .push    (rc_push),
    .way_in  (cache_hit_way),
    .out_set (rec_set),
    .at_last (rc_last)
  );

  assign mode     = mode_q;
  assign skip_tag = (mode_q == MODE_OMIT);
  assign omit_way = (mode_q == MODE_OMIT) ? rp_way : '0;
endmodule

// File: rtl/wp_mode_ctrl_chk.sv
module wp_mode_ctrl_chk #(
  parameter int PTRS  = 4,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btb_hit,
  input logic             btb_repl,
  input logic             ras_target,
  input logic             br_mispredict,
  input logic             line_cross,
  input logic             cache_miss,
  input logic [1:0]       mode,
  input logic [WAY_W-1:0] omit_way,
  input logic             skip_tag
);
  logic flush, hold;
  logic [$clog2(PTRS+1)-1:0] lines_q;
  assign flush = cache_miss || btb_repl;
  assign hold  = ras_target || br_mispredict;

  // strobes seen since the last accepted BTB hit, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else if (btb_hit && !flush && !hold) lines_q <= '0;
    else if (line_cross && lines_q != PTRS[$clog2(PTRS+1)-1:0]) lines_q <= lines_q + 1'b1;
  end

  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3));

  // R2
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !btb_hit) |=> (mode == 2'd0));

  // R2
  skip_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!skip_tag) |-> (omit_way == '0));

  // R4
  omit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && $past(mode) != 2'd1) |-> $past(btb_hit));

  // R11
  flush_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mode == 2'd0 && !skip_tag));

  // R12
  redirect_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (mode == 2'd0));

  // R9
  omit_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && line_cross && !btb_hit && !flush && !hold &&
     lines_q == PTRS[$clog2(PTRS+1)-1:0] - 1'b1) |=> (mode == 2'd0));
endmodule

bind wp_mode_ctrl wp_mode_ctrl_chk #(.PTRS(PTRS), .WAY_W(WAY_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .btb_hit       (btb_hit),
  .btb_repl      (btb_repl),
  .ras_target    (ras_target),
  .br_mispredict (br_mispredict),
  .line_cross    (line_cross),
  .cache_miss    (cache_miss),
  .mode          (mode),
  .omit_way      (omit_way),
  .skip_tag      (skip_tag)
);

// File: tb/wp_mode_ctrl_test.sv
`timescale 1ns/1ps
module wp_mode_ctrl_test;
  localparam logic [1:0] NRM = 2'd0, OMT = 2'd1, TRC = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       btb_hit, btb_repl, pred_taken, ras_target, br_mispredict;
  logic       line_cross, cache_miss;
  logic [3:0] btb_idx;
  logic [1:0] cache_hit_way;
  logic [1:0] mode, omit_way;
  logic       skip_tag;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  wp_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .btb_hit(btb_hit), .btb_idx(btb_idx),
    .btb_repl(btb_repl), .pred_taken(pred_taken), .ras_target(ras_target),
    .br_mispredict(br_mispredict), .line_cross(line_cross),
    .cache_hit_way(cache_hit_way), .cache_miss(cache_miss),
    .mode(mode), .omit_way(omit_way), .skip_tag(skip_tag)
  );

  task automatic idle();
    btb_hit = 0; btb_idx = '0; btb_repl = 0; pred_taken = 0; ras_target = 0;
    br_mispredict = 0; line_cross = 0; cache_hit_way = '0; cache_miss = 0;
  endtask

  // present inputs for one cycle from a falling edge, end on the next one
  task automatic cyc(input logic hit, input logic [3:0] idx, input logic tk,
                     input logic [1:0] hw, input logic lb, input logic miss,
                     input logic repl, input logic ras, input logic misp);
    btb_hit = hit; btb_idx = idx; pred_taken = tk; cache_hit_way = hw;
    line_cross = lb; cache_miss = miss; btb_repl = repl; ras_target = ras;
    br_mispredict = misp;
    @(negedge clk);
    idle();
  endtask

  task automatic hit(input logic [3:0] idx, input logic tk, input logic [1:0] hw);
    cyc(1, idx, tk, hw, 0, 0, 0, 0, 0);
  endtask

  task automatic strobe(input logic [1:0] hw);
    cyc(0, 4'd0, 0, hw, 1, 0, 0, 0, 0);
  endtask

  task automatic expect_out(input logic [1:0] m, input logic [1:0] w, input logic sk,
                            input string tag);
    checks++;
    if (mode !== m || omit_way !== w || skip_tag !== sk) begin
      errors++;
      $display("FAIL %s: mode=%0d way=%0d skip=%0b, expected mode=%0d way=%0d skip=%0b",
               tag, mode, omit_way, skip_tag, m, w, sk);
    end
  endtask

  task automatic t_reset();
    expect_out(NRM, 2'd0, 0, "R1 reset outputs");
    strobe(2'd3);
    expect_out(NRM, 2'd0, 0, "R2 normal ignores strobe");
  endtask

  // entry 3 taken recorded as 1,2,3 (three lines)
  task automatic t_record_taken();
    hit(4'd3, 1, 2'd0);
    expect_out(TRC, 2'd0, 0, "R1 R3 first hit traces");
    strobe(2'd1);
    strobe(2'd2);
    expect_out(TRC, 2'd0, 0, "R7 trace across strobes");
    hit(4'd5, 1, 2'd3);
    expect_out(TRC, 2'd0, 0, "R3 second entry traces");
    cyc(0, 4'd0, 0, 2'd0, 0, 0, 0, 0, 1);
    expect_out(NRM, 2'd0, 0, "R12 mispredict to normal");
  endtask

  task automatic t_replay_taken();
    hit(4'd3, 1, 2'd0);
    expect_out(OMT, 2'd1, 1, "R4 R7 omit pointer0");
    strobe(2'd0);
    expect_out(OMT, 2'd2, 1, "R6 pointer1");
    strobe(2'd0);
    expect_out(OMT, 2'd3, 1, "R6 R7 pointer2 tail");
  endtask

  task automatic t_trace_overflow();
    hit(4'd3, 0, 2'd0);
    expect_out(TRC, 2'd0, 0, "R5 not-taken half invalid");
    strobe(2'd0); strobe(2'd1); strobe(2'd2);
    expect_out(TRC, 2'd0, 0, "R10 M-1 stored still trace");
    strobe(2'd3);
    expect_out(NRM, 2'd0, 0, "R10 trace overflow");
    hit(4'd3, 0, 2'd0);
    expect_out(TRC, 2'd0, 0, "R10 overflowed set not written");
  endtask

  // continues from trace on entry 3 not-taken: full M=4 lines 0,1,2,3
  task automatic t_full_record_and_overflow();
    strobe(2'd0); strobe(2'd1); strobe(2'd2);
    hit(4'd3, 0, 2'd3);
    expect_out(TRC, 2'd0, 0, "R8 same-cycle write not seen");
    cyc(0, 4'd0, 0, 2'd0, 0, 0, 0, 1, 0);
    expect_out(NRM, 2'd0, 0, "R12 return stack to normal");
    hit(4'd3, 0, 2'd0);
    expect_out(OMT, 2'd0, 1, "R8 next hit omits");
    strobe(2'd0); strobe(2'd0); strobe(2'd0);
    expect_out(OMT, 2'd3, 1, "R6 pointer3");
    strobe(2'd0);
    expect_out(NRM, 2'd0, 0, "R9 omit overflow");
    hit(4'd3, 1, 2'd0);
    expect_out(OMT, 2'd1, 1, "R5 R12 taken half kept valid");
  endtask

  task automatic t_priority();
    cyc(1, 4'd3, 0, 2'd0, 1, 0, 0, 0, 0);
    expect_out(OMT, 2'd0, 1, "R13 hit beats strobe");
    cyc(1, 4'd3, 1, 2'd0, 0, 0, 0, 1, 0);
    expect_out(NRM, 2'd0, 0, "R13 return stack beats hit");
    hit(4'd3, 1, 2'd0);
    expect_out(OMT, 2'd1, 1, "R12 valid kept after redirect");
    cyc(1, 4'd3, 1, 2'd0, 0, 1, 0, 1, 0);
    expect_out(NRM, 2'd0, 0, "R11 R13 miss beats hit");
    hit(4'd3, 1, 2'd0);
    expect_out(TRC, 2'd0, 0, "R11 miss cleared taken half");
    hit(4'd3, 0, 2'd0);
    expect_out(TRC, 2'd0, 0, "R11 miss cleared not-taken half");
  endtask

  task automatic t_replacement();
    hit(4'd7, 1, 2'd0);
    hit(4'd8, 1, 2'd2);
    expect_out(TRC, 2'd0, 0, "R7 single-line record");
    cyc(0, 4'd0, 0, 2'd0, 0, 0, 0, 1, 0);
    hit(4'd7, 1, 2'd0);
    expect_out(OMT, 2'd2, 1, "R7 tail way stored");
    cyc(0, 4'd0, 0, 2'd0, 0, 0, 1, 0, 0);
    expect_out(NRM, 2'd0, 0, "R11 replacement to normal");
    hit(4'd7, 1, 2'd0);
    expect_out(TRC, 2'd0, 0, "R11 replacement cleared");
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_record_taken();
    t_replay_taken();
    t_trace_overflow();
    t_full_record_and_overflow();
    t_priority();
    t_replacement();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule